// File: doc/BRIEF.md
# Partitioned 8x16 Fractional Multiplier

This unit multiplies narrow unsigned pixel components by signed 16-bit fixed-point factors, several lanes at once. Each lane takes an unsigned 8-bit operand and a signed 16-bit operand and forms their 25-bit signed product. It keeps product bits 23..8 as a 16-bit fractional result and rounds that result up when product bit 7 is set. The rounded value wraps within 16 bits.

A 3-bit operation code picks one of seven variants. The variants differ in three ways: where the 8-bit operand comes from, whether the 16-bit factor is per lane or shared by all lanes, and whether the result fills four 16-bit lanes or two widened 32-bit lanes. Code 7 is unused and gives an all-zero result.

The unit has a two-stage pipeline. The first stage selects the operands and registers the lane products. The second stage rounds, packs and registers the result. A valid flag travels alongside the data. When no operation completes, the result register holds its last value.

Operation codes (enumerated): 0 `OP_BASIC`, 1 `OP_SHR_HI`, 2 `OP_SHR_LO`, 3 `OP_BYTE_HI`, 4 `OP_BYTE_LO`, 5 `OP_WIDE_HI`, 6 `OP_WIDE_LO`, 7 `OP_NONE`. Pipeline stage occupancy moves as follows:
- idle to stage 1 when `in_valid` is high;
- stage 1 to the output register on the next edge;
- otherwise the output is held.

Top module: `lane_frac_mul`

## Requirements
- R1: With code 0, lane i (i = 0..3) multiplies unsigned byte `src_a[8i+7:8i]` by signed `src_b[16i+15:16i]`.
- R2: Each lane result is bits 23..8 of the 25-bit signed product, plus one when product bit 7 is set, taken modulo 2^16. For example, 0x80 times 0xFFFF gives 0x0000.
- R3: With code 1, every lane multiplies unsigned byte `src_a[8i+7:8i]` by signed `src_b[31:16]`. With code 2 the shared factor is signed `src_b[15:0]`.
- R4: With code 3, lane i uses byte `src_a[16i+15:16i+8]`. With code 4 it uses byte `src_a[16i+7:16i]`. In both codes the factor is signed `src_b[16i+15:16i]`.
- R5: Codes 5 and 6 compute only lanes 0 and 1, taking operands as in codes 3 and 4 respectively. Each rounded lane result is placed at `res[32i+22:32i+7]`, and every other result bit is zero.
- R6: In codes 0 to 4, lane i of the result occupies `res[16i+15:16i]`.
- R7: `res_valid` is high exactly two clock edges after an edge at which `in_valid` was high. The result for that operation appears in the same cycle.
- R8: When no operation completes, `res` keeps its previous value. After reset, `res` is zero and `res_valid` is low.
- R9: Code 7 produces an all-zero result with `res_valid` raised as usual.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_sel | input | 3 | Operation code |
| src_a | input | 64 | Source of the 8-bit operands |
| src_b | input | 64 | Source of the 16-bit operands |
| in_valid | input | 1 | Operation issue strobe |
| res | output | 64 | Packed rounded result |
| res_valid | output | 1 | Result valid flag |

## Verification
The two functions that share a cycle are new operand capture in stage 1 and rounding and packing of the previous operation in stage 2. Issuing operations back to back with a different code each time provokes this, so a stale code or product would corrupt the packed lanes. Idle gaps are mixed into the same stream to check that the result is held. A behavioural model with a two-deep expectation pipeline judges the result and the valid flag on every clock.

// File: rtl/lfm_pkg.sv
package lfm_pkg;
    typedef enum logic [2:0] {
        OP_BASIC   = 3'd0,
        OP_SHR_HI  = 3'd1,
        OP_SHR_LO  = 3'd2,
        OP_BYTE_HI = 3'd3,
        OP_BYTE_LO = 3'd4,
        OP_WIDE_HI = 3'd5,
        OP_WIDE_LO = 3'd6,
        OP_NONE    = 3'd7
    } lfm_op_e;
endpackage

// File: rtl/lfm_operand_sel.sv
module lfm_operand_sel #(
    parameter int LANES = 4,
    parameter int AW    = 8,
    parameter int BW    = 16,
    localparam int DW   = LANES * BW
) (
    input  lfm_pkg::lfm_op_e               op,
    input  logic [DW-1:0]                  src_a,
    input  logic [DW-1:0]                  src_b,
    output logic [LANES-1:0][AW-1:0]       a_lane,
    output logic [LANES-1:0][BW-1:0]       b_lane
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_comb begin
            unique case (op)
                lfm_pkg::OP_BASIC: begin
                    a_lane[g] = src_a[AW*g +: AW];
                    b_lane[g] = src_b[BW*g +: BW];
                end
                lfm_pkg::OP_SHR_HI: begin
                    a_lane[g] = src_a[AW*g +: AW];
                    b_lane[g] = src_b[BW +: BW];
                end
                lfm_pkg::OP_SHR_LO: begin
                    a_lane[g] = src_a[AW*g +: AW];
                    b_lane[g] = src_b[0 +: BW];
                end
                lfm_pkg::OP_BYTE_HI, lfm_pkg::OP_WIDE_HI: begin
                    a_lane[g] = src_a[BW*g + AW +: AW];
                    b_lane[g] = src_b[BW*g +: BW];
                end
                lfm_pkg::OP_BYTE_LO, lfm_pkg::OP_WIDE_LO: begin
                    a_lane[g] = src_a[BW*g +: AW];
                    b_lane[g] = src_b[BW*g +: BW];
                end
                default: begin
                    a_lane[g] = '0;
                    b_lane[g] = '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/lfm_lane_mul.sv
module lfm_lane_mul #(
    parameter int AW  = 8,
    parameter int BW  = 16,
    localparam int PW = AW + BW + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic [AW-1:0]        a,
    input  logic [BW-1:0]        b,
    output logic [PW-1:0]        prod
);
    logic signed [PW-1:0] a_ext;
    logic signed [PW-1:0] b_ext;
    logic signed [PW-1:0] full;

    assign a_ext = {{(PW-AW){1'b0}}, a};
    assign b_ext = {{(PW-BW){b[BW-1]}}, b};
    assign full  = a_ext * b_ext;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prod <= '0;
        end else if (en) begin
            prod <= full;
        end
    end
endmodule

// File: rtl/lfm_round_pack.sv
module lfm_round_pack #(
    parameter int LANES = 4,
    parameter int AW    = 8,
    parameter int BW    = 16,
    localparam int PW   = AW + BW + 1,
    localparam int DW   = LANES * BW,
    localparam int WL   = LANES / 2,
    localparam int WSH  = AW - 1
) (
    input  lfm_pkg::lfm_op_e           op,
    input  logic [LANES-1:0][PW-1:0]   prod,
    output logic [DW-1:0]              packed_res
);
    logic [LANES-1:0][BW-1:0] rnd;

    for (genvar g = 0; g < LANES; g++) begin : g_rnd
        assign rnd[g] = prod[g][AW+BW-1:AW] + BW'(prod[g][AW-1]);
    end

    always_comb begin
        packed_res = '0;
        unique case (op)
            lfm_pkg::OP_WIDE_HI, lfm_pkg::OP_WIDE_LO: begin
                for (int i = 0; i < WL; i++) begin
                    packed_res[2*BW*i + WSH +: BW] = rnd[i];
                end
            end
            lfm_pkg::OP_NONE: begin
                packed_res = '0;
            end
            default: begin
                for (int i = 0; i < LANES; i++) begin
                    packed_res[BW*i +: BW] = rnd[i];
                end
            end
        endcase
    end
endmodule

// File: rtl/lane_frac_mul.sv
module lane_frac_mul #(
    parameter int LANES = 4,
    parameter int AW    = 8,
    parameter int BW    = 16,
    localparam int PW   = AW + BW + 1,
    localparam int DW   = LANES * BW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    op_sel,
    input  logic [63:0]   src_a,
    input  logic [63:0]   src_b,
    input  logic          in_valid,
    output logic [63:0]   res,
    output logic          res_valid
);
    lfm_pkg::lfm_op_e          op_in;
    lfm_pkg::lfm_op_e          s1_op;
    logic                      s1_valid;
    logic [LANES-1:0][AW-1:0]  a_lane;
    logic [LANES-1:0][BW-1:0]  b_lane;
    logic [LANES-1:0][PW-1:0]  s1_prod;
    logic [DW-1:0]             packed_res;

    assign op_in = lfm_pkg::lfm_op_e'(op_sel);

    lfm_operand_sel #(.LANES(LANES), .AW(AW), .BW(BW)) u_sel (
        .op     (op_in),
        .src_a  (src_a[DW-1:0]),
        .src_b  (src_b[DW-1:0]),
        .a_lane (a_lane),
        .b_lane (b_lane)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_mul
        lfm_lane_mul #(.AW(AW), .BW(BW)) u_mul (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (in_valid),
            .a     (a_lane[g]),
            .b     (b_lane[g]),
            .prod  (s1_prod[g])
        );
    end

    // stage 1 control
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_op    <= lfm_pkg::OP_NONE;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_op <= op_in;
            end
        end
    end

    lfm_round_pack #(.LANES(LANES), .AW(AW), .BW(BW)) u_pack (
        .op         (s1_op),
        .prod       (s1_prod),
        .packed_res (packed_res)
    );

    // stage 2 output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res       <= '0;
            res_valid <= 1'b0;
        end else begin
            res_valid <= s1_valid;
            if (s1_valid) begin
                res <= 64'(packed_res);
            end
        end
    end
endmodule

// File: rtl/lfm_chk.sv
module lfm_chk #(
    parameter int DW = 64,
    parameter int BW = 16,
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [2:0]    op_sel,
    input logic [63:0]   src_a,
    input logic          in_valid,
    input logic [63:0]   res,
    input logic          res_valid
);
    localparam logic [63:0] LANE_ONES = {{(64-BW){1'b0}}, {BW{1'b1}}};
    localparam logic [63:0] WIDE_KEEP = (LANE_ONES << (AW-1)) | (LANE_ONES << (2*BW + AW - 1));

    // R7
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid == $past(in_valid, 2));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid, 2) |-> $stable(res));

    // R5
    wide_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(in_valid, 2) && ($past(op_sel, 2) == 3'd5 || $past(op_sel, 2) == 3'd6))
        |-> ((res & ~WIDE_KEEP) == 64'd0));

    // R9
    none_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(in_valid, 2) && $past(op_sel, 2) == 3'd7) |-> (res == 64'd0));

    // R1
    basic_zero_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(in_valid, 2) && $past(op_sel, 2) == 3'd0 && $past(src_a[7:0], 2) == 8'd0)
        |-> (res[15:0] == 16'd0));
endmodule

bind lane_frac_mul lfm_chk #(.DW(DW), .BW(BW), .AW(AW)) u_chk (.*);

// File: tb/lane_frac_mul_bench.sv
module lane_frac_mul_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_sel = 3'd0;
    logic [63:0] src_a = 64'd0;
    logic [63:0] src_b = 64'd0;
    logic        in_valid = 1'b0;
    logic [63:0] res;
    logic        res_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    lane_frac_mul u_lane_frac_mul (
        .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .src_a(src_a),
        .src_b(src_b), .in_valid(in_valid), .res(res), .res_valid(res_valid)
    );

    // R2: keep product bits 23..8, add bit 7, wrap in 16 bits
    function automatic logic [15:0] lane_val(int unsigned a8, logic [15:0] b16);
        int p;
        logic [31:0] pp;
        p  = int'(a8) * int'($signed(b16));
        pp = p;
        return pp[23:8] + {15'd0, pp[7]};
    endfunction

    function automatic logic [63:0] model(logic [2:0] op, logic [63:0] a, logic [63:0] b);
        logic [63:0] r = 64'd0;
        for (int i = 0; i < 4; i++) begin
            case (op)
                3'd0: r[16*i +: 16] = lane_val(a[8*i +: 8], b[16*i +: 16]);
                3'd1: r[16*i +: 16] = lane_val(a[8*i +: 8], b[31:16]);
                3'd2: r[16*i +: 16] = lane_val(a[8*i +: 8], b[15:0]);
                3'd3: r[16*i +: 16] = lane_val(a[16*i+8 +: 8], b[16*i +: 16]);
                3'd4: r[16*i +: 16] = lane_val(a[16*i +: 8], b[16*i +: 16]);
                3'd5: if (i < 2) r[32*i+7 +: 16] = lane_val(a[16*i+8 +: 8], b[16*i +: 16]);
                3'd6: if (i < 2) r[32*i+7 +: 16] = lane_val(a[16*i +: 8], b[16*i +: 16]);
                default: r = 64'd0;
            endcase
        end
        return r;
    endfunction

    function automatic string tag_of(logic [2:0] op);
        case (op)
            3'd0: return "R1/R6";
            3'd1, 3'd2: return "R3";
            3'd3, 3'd4: return "R4";
            3'd5, 3'd6: return "R5";
            default: return "R9";
        endcase
    endfunction

    // expectation pipeline: p0 = issued one edge ago, p1 = two edges ago
    logic        p0_v = 1'b0, p1_v = 1'b0;
    logic [2:0]  p0_op = 3'd0, p1_op = 3'd0;
    logic [63:0] p0_d = 64'd0, p1_d = 64'd0;
    logic [63:0] held = 64'd0;

    task automatic check_cycle();
        string t;
        logic [63:0] exp_d;
        if (p1_v) held = p1_d;
        exp_d = held;
        t = p1_v ? tag_of(p1_op) : "R8";
        checks++;
        if (res_valid !== p1_v) begin
            fails++;
            $display("FAIL R7 res_valid actual %0b expected %0b", res_valid, p1_v);
        end else if (res !== exp_d) begin
            fails++;
            $display("FAIL %s res actual %h expected %h", t, res, exp_d);
        end
    endtask

    task automatic step(logic v, logic [2:0] op, logic [63:0] a, logic [63:0] b);
        @(negedge clk);
        check_cycle();
        p1_v = p0_v; p1_op = p0_op; p1_d = p0_d;
        p0_v = v; p0_op = op; p0_d = model(op, a, b);
        in_valid = v; op_sel = op; src_a = a; src_b = b;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        checks++;
        if (res !== 64'd0 || res_valid !== 1'b0) begin
            fails++;
            $display("FAIL R8 reset res %h valid %0b expected 0 0", res, res_valid);
        end
        rst_n = 1'b1;
        // R2 corners: round-up from bit 7, and wrap of 0x80 * -1 to zero
        step(1, 3'd0, 64'h0000_0000_0000_8001, 64'h0000_0000_FFFF_0080);
        step(1, 3'd0, 64'h0000_0000_FFFF_FFFF, 64'h8000_7FFF_8000_7FFF);
        // R3 shared factor, both halves
        step(1, 3'd1, 64'h0000_0000_FF80_4001, 64'h0000_0000_8000_1234);
        step(1, 3'd2, 64'h0000_0000_FF80_4001, 64'h0000_0000_8000_1234);
        // R4 upper/lower bytes of each 16-bit lane
        step(1, 3'd3, 64'hAB01_00FF_7F80_1234, 64'hFFFF_7FFF_8000_0100);
        step(1, 3'd4, 64'hAB01_00FF_7F80_1234, 64'hFFFF_7FFF_8000_0100);
        // R5 widened placement
        step(1, 3'd5, 64'hFFFF_FFFF_FF80_FF01, 64'hFFFF_FFFF_8000_7FFF);
        step(1, 3'd6, 64'hFFFF_FFFF_FF80_FF01, 64'hFFFF_FFFF_8000_7FFF);
        // R9 unused code
        step(1, 3'd7, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1234_5678_9ABC_DEF0);
        // R8 idle gap with changing inputs
        step(0, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h7FFF_7FFF_7FFF_7FFF);
        step(0, 3'd3, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888);
        step(0, 3'd1, 64'h0, 64'h0);
        // back-to-back mixed codes with random gaps (R7)
        for (int n = 0; n < 600; n++) begin
            logic v;
            v = ($urandom % 4) != 0;
            step(v, 3'($urandom % 8), {$urandom, $urandom}, {$urandom, $urandom});
        end
        step(0, 3'd0, 64'h0, 64'h0);
        step(0, 3'd0, 64'h0, 64'h0);
        step(0, 3'd0, 64'h0, 64'h0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule